// File: doc/BRIEF.md
# I2C Register Access Slave

This block is an I2C-compatible target that lets a host reach an 8-bit register bank through two wires, SCL and SDA, at bus rates up to 400 kHz. Both lines are brought into the system clock domain through two flip-flops. The block detects START, repeated START and STOP from the synchronised lines. It responds only when the seven address bits sent after a START match a fixed five-bit prefix joined with two strap pins. SDA is open drain: the block never drives it high.

In a write transfer, the first byte after the address loads a register pointer. Each byte after that becomes a single-cycle write strobe on the core-side register bus. In a read transfer, the block fetches a byte from the pointer with a single-cycle read strobe and shifts it out MSB first. It keeps fetching while the host acknowledges. After each access the pointer steps forward, except at address 0, which is a streaming port. The core-side bus is the same one an SPI front end would use, so either front end can sit in front of the same register bank.

Top module: `i2c_reg_slave`

## Requirements
- R1: While rst_n is low, and in the first cycle after it, sda_oe, reg_wr and reg_rd are all low.
- R2: The first byte after a START is matched as {01011, addr_pin[1], addr_pin[0]} in bits 7..1 with the read/write flag in bit 0 (1 = read). On a match the block drives SDA low for the ninth clock.
- R3: On an address mismatch the block does not acknowledge, issues no reg_wr or reg_rd, and keeps sda_oe low until the next START or STOP.
- R4: In a write, the first byte after the address loads the pointer (its low AW bits). Every later byte gives exactly one reg_wr pulse with reg_addr = pointer and reg_wdata = byte, and is acknowledged.
- R5: After each reg_wr or reg_rd the pointer advances by one and wraps from 2^AW-1 to 0. A pointer of 0 never advances.
- R6: In a read, each byte comes from one reg_rd pulse at the pointer and is sent MSB first. A host ACK fetches the next byte. A host NACK releases SDA and ends the transfer.
- R7: A repeated START begins a new addressed transfer, and the pointer keeps its value across transfers.
- R8: A STOP returns the block to idle with SDA released.
- R9: sda_oe asserts only to pull SDA low. reg_wr and reg_rd are never high in the same cycle, and each write pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_pin | input | 2 | Strap pins for the two low address bits |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_addr | output | AW | Register pointer presented to the core |
| reg_wdata | output | 8 | Write data, valid with reg_wr |
| reg_wr | output | 1 | Single-cycle register write strobe |
| reg_rd | output | 1 | Single-cycle register read strobe |
| reg_rdata | input | 8 | Register contents at reg_addr, combinational from the core |

## Verification
The bench builds the block with its defaults: AW = 7 and prefix 01011. With a 7-bit pointer, the wrap from 0x7F to 0x00 takes only one pointer byte and two data bytes. After the wrap, the streaming-port rule keeps the pointer at 0, and a later read proves that the pointer persists. The bench changes the strap pins during the run, so one address that was acknowledged becomes a mismatch and a new one becomes valid. This covers both sides of the address compare.

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave #(
  parameter int AW = 7,
  parameter logic [4:0] PREFIX = 5'b01011
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    addr_pin,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          sda_oe,
  output logic [AW-1:0] reg_addr,
  output logic [7:0]    reg_wdata,
  output logic          reg_wr,
  output logic          reg_rd,
  input  logic [7:0]    reg_rdata
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_WR, S_WACK, S_RD, S_RACK} state_t;

  state_t        state;
  logic [2:0]    scl_q, sda_q;
  logic [7:0]    sh;
  logic [3:0]    cnt;
  logic [AW-1:0] ptr;
  logic          rw, have_ptr, nack;

  wire scl_rise = scl_q[1] & ~scl_q[2];
  wire scl_fall = ~scl_q[1] & scl_q[2];
  wire start_det = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  wire stop_det  = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];

  assign reg_addr  = ptr;
  assign reg_wdata = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_in};
      sda_q <= {sda_q[1:0], sda_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; sh <= '0; cnt <= '0; ptr <= '0;
      rw <= 1'b0; have_ptr <= 1'b0; nack <= 1'b0;
      sda_oe <= 1'b0; reg_wr <= 1'b0; reg_rd <= 1'b0;
    end else begin
      reg_wr <= 1'b0;
      reg_rd <= 1'b0;
      if ((reg_wr || reg_rd) && ptr != '0) ptr <= ptr + 1'b1;
      if (reg_rd) begin
        sh     <= reg_rdata;
        sda_oe <= ~reg_rdata[7];
      end
      if (start_det) begin
        state <= S_ADDR; cnt <= '0; sda_oe <= 1'b0;
      end else if (stop_det) begin
        state <= S_IDLE; sda_oe <= 1'b0;
      end else begin
        case (state)
          S_ADDR, S_WR: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_q[1]};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (state == S_ADDR) begin
                if (sh[7:1] == {PREFIX, addr_pin}) begin
                  rw <= sh[0]; sda_oe <= 1'b1; state <= S_AACK;
                end else begin
                  state <= S_IDLE;
                end
              end else begin
                if (!have_ptr) begin
                  ptr <= sh[AW-1:0]; have_ptr <= 1'b1;
                end else begin
                  reg_wr <= 1'b1;
                end
                sda_oe <= 1'b1; state <= S_WACK;
              end
            end
          end
          S_AACK: if (scl_fall) begin
            cnt <= '0; have_ptr <= 1'b0;
            if (rw) begin
              reg_rd <= 1'b1; state <= S_RD;
            end else begin
              sda_oe <= 1'b0; state <= S_WR;
            end
          end
          S_WACK: if (scl_fall) begin
            sda_oe <= 1'b0; cnt <= '0; state <= S_WR;
          end
          S_RD: if (scl_fall) begin
            if (cnt == 4'd7) begin
              sda_oe <= 1'b0; state <= S_RACK;
            end else begin
              sh <= {sh[6:0], 1'b0}; sda_oe <= ~sh[6]; cnt <= cnt + 1'b1;
            end
          end
          S_RACK: begin
            if (scl_rise) nack <= sda_q[1];
            else if (scl_fall) begin
              if (nack) state <= S_IDLE;
              else begin
                cnt <= '0; reg_rd <= 1'b1; state <= S_RD;
              end
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(reg_wr && reg_rd)); // R9
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) reg_wr |=> !reg_wr); // R4
  AST_PORT0_HOLD: assert property (@(posedge clk) disable iff (!rst_n) ((reg_wr || reg_rd) && reg_addr == '0) |=> reg_addr == '0); // R5
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n) ((reg_wr || reg_rd) && reg_addr != '0) |=> reg_addr == AW'($past(reg_addr) + 1'b1)); // R5
  AST_STOP_FREE: assert property (@(posedge clk) disable iff (!rst_n) stop_det |=> !sda_oe); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (state == S_IDLE && !start_det) |=> !sda_oe); // R3

endmodule

// File: tb/i2c_reg_slave_tb.sv
module i2c_reg_slave_tb;
  localparam int Q = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr_pin = 2'b10;
  logic       scl = 1'b1, sda_m = 1'b1;
  logic       sda_oe, reg_wr, reg_rd;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] core_mem [128];
  wire        sda_line = sda_m & ~sda_oe;
  wire [7:0]  reg_rdata = core_mem[reg_addr];

  int compared = 0, mismatched = 0;
  logic [14:0] exp_wr [$];
  bit quiet = 1'b0;

  always #5 clk = ~clk;

  i2c_reg_slave u_dut (
    .clk(clk), .rst_n(rst_n), .addr_pin(addr_pin), .scl_in(scl), .sda_in(sda_line),
    .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  always @(posedge clk) if (reg_wr) core_mem[reg_addr] <= reg_wdata;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // per-clock comparison of the register bus and quiet-bus expectation
  always @(negedge clk) if (rst_n) begin
    if (reg_wr) begin
      if (exp_wr.size() == 0) check(1'b0, "R3/R4 unexpected reg_wr", {reg_addr, reg_wdata}, 0);
      else begin
        logic [14:0] e;
        e = exp_wr.pop_front();
        check({reg_addr, reg_wdata} == e, "R4/R5 write addr+data", {reg_addr, reg_wdata}, e);
      end
    end
    if (quiet && (sda_oe || reg_rd)) check(1'b0, "R3 bus touched after mismatch", sda_oe, 0);
  end

  task automatic wq(input int n); repeat (n) @(negedge clk); endtask
  task automatic i2c_start; sda_m = 1; wq(Q); scl = 1; wq(Q); sda_m = 0; wq(Q); scl = 0; wq(Q); endtask
  task automatic i2c_stop; sda_m = 0; wq(Q); scl = 1; wq(Q); sda_m = 1; wq(Q); endtask
  task automatic put_bit(input bit b); sda_m = b; wq(Q); scl = 1; wq(2*Q); scl = 0; wq(Q); endtask
  task automatic get_bit(output bit b); sda_m = 1; wq(Q); scl = 1; wq(Q); b = sda_line; wq(Q); scl = 0; wq(Q); endtask

  task automatic send(input logic [7:0] v, output bit acked);
    bit b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    acked = !b;
  endtask

  task automatic recv(output logic [7:0] v, input bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(!ack);
  endtask

  task automatic send_chk(input logic [7:0] v, input bit exp_ack, input string tag);
    bit a;
    send(v, a);
    check(a == exp_ack, tag, a, exp_ack);
  endtask

  task automatic recv_chk(input logic [7:0] exp, input bit ack, input string tag);
    logic [7:0] v;
    recv(v, ack);
    check(v == exp, tag, v, exp);
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        mismatched++;
        $display("FAIL watchdog: actual %0d expected <150000 cycles", wd);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) core_mem[i] = 8'h00;
    wq(5);
    check(!sda_oe && !reg_wr && !reg_rd, "R1 reset outputs", {sda_oe, reg_wr, reg_rd}, 0);
    rst_n = 1;
    wq(1);
    check(!sda_oe && !reg_wr && !reg_rd, "R1 first cycle after reset", {sda_oe, reg_wr, reg_rd}, 0);
    wq(10);

    // write three bytes from pointer 0x10 (address 0x2E with pins 10)
    i2c_start;
    send_chk(8'h5C, 1, "R2 address ack (write)");
    send_chk(8'h10, 1, "R4 pointer ack");
    exp_wr.push_back({7'h10, 8'hA1}); send_chk(8'hA1, 1, "R4 data ack");
    exp_wr.push_back({7'h11, 8'hB2}); send_chk(8'hB2, 1, "R4 data ack");
    exp_wr.push_back({7'h12, 8'hC3}); send_chk(8'hC3, 1, "R4 data ack");
    i2c_stop;
    wq(4);
    check(!sda_oe, "R8 SDA released after STOP", sda_oe, 0);
    check(exp_wr.size() == 0, "R4 all writes seen", exp_wr.size(), 0);

    // pointer set, repeated START, read three bytes
    i2c_start;
    send_chk(8'h5C, 1, "R2 address ack");
    send_chk(8'h10, 1, "R4 pointer ack");
    i2c_start;
    send_chk(8'h5D, 1, "R7 repeated START read address ack");
    recv_chk(8'hA1, 1, "R6 read byte 0");
    recv_chk(8'hB2, 1, "R6 read byte 1");
    recv_chk(8'hC3, 0, "R6 read byte 2");
    check(!sda_oe, "R6 SDA released after NACK", sda_oe, 0);
    i2c_stop;

    // mismatched address: write then read
    i2c_start;
    send_chk(8'h58, 0, "R3 mismatch not acked");
    quiet = 1;
    send_chk(8'h10, 0, "R3 later byte ignored");
    send_chk(8'h55, 0, "R3 later byte ignored");
    quiet = 0;
    i2c_start;
    send_chk(8'h59, 0, "R3 mismatch read not acked");
    quiet = 1;
    recv_chk(8'hFF, 0, "R3 bus released on mismatched read");
    quiet = 0;
    i2c_stop;

    // streaming port at address 0
    i2c_start;
    send_chk(8'h5C, 1, "R2 address ack");
    send_chk(8'h00, 1, "R5 pointer 0 ack");
    exp_wr.push_back({7'h00, 8'h11}); send_chk(8'h11, 1, "R5 port0 write");
    exp_wr.push_back({7'h00, 8'h22}); send_chk(8'h22, 1, "R5 port0 write");
    i2c_start;
    send_chk(8'h5D, 1, "R7 read after repeated START");
    recv_chk(8'h22, 1, "R5 port0 read holds");
    recv_chk(8'h22, 0, "R5 port0 read holds");
    i2c_stop;

    // new strap pins, pointer wrap
    addr_pin = 2'b01;
    wq(4);
    i2c_start;
    send_chk(8'h5A, 1, "R2 ack with new pins");
    send_chk(8'h7F, 1, "R4 pointer ack");
    exp_wr.push_back({7'h7F, 8'h77}); send_chk(8'h77, 1, "R5 write at top");
    exp_wr.push_back({7'h00, 8'h88}); send_chk(8'h88, 1, "R5 write after wrap");
    i2c_stop;
    i2c_start;
    send_chk(8'h5C, 0, "R3 old address now mismatched");
    i2c_stop;

    // pointer persists across transfers (wrapped to 0, held)
    i2c_start;
    send_chk(8'h5B, 1, "R7 read without new pointer");
    recv_chk(8'h88, 1, "R7 pointer persisted");
    recv_chk(8'h88, 0, "R5 port0 held after wrap");
    i2c_stop;
    wq(10);
    check(exp_wr.size() == 0, "R4 all writes seen", exp_wr.size(), 0);
    check(!sda_oe, "R9 line released at end", sda_oe, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule